// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block controls a bank of 32 general-purpose pins behind a flat, word-wide register port with a combinational read path. Each pin can be an input or an output. Software can load the value a pin will drive before it turns the pin into an output. Every pin input goes through a synchronizer, and the synchronized level can be read back. On any pin, rising and falling transitions can each be enabled on their own. An enabled transition is latched in a sticky status word.

Status bits reach the single interrupt output only where the forwarding mask lets them through. Direction, output data, both edge enables and the forwarding mask each have a pair of alias addresses: one sets bits and one clears bits. Software therefore never needs a read-modify-write to change a single pin. Status bits are cleared by writing one to them. If a new edge arrives in the same cycle as a clear, the edge is kept.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous active-low reset, direction, output data, rising enable, falling enable, forwarding mask and edge status are all 0, so pin_oe, pin_out and irq are 0.
- R2: A write to a set alias ORs the written word into its register, and a write to a clear alias removes the bits written as 1. The alias pairs are 0x54/0x60 for direction, 0x18/0x24 for output data, 0x6C/0x78 for rising enable, 0x84/0x90 for falling enable and 0x9C/0xA8 for the forwarding mask. Bits written as 0 do not change, and the register updates on the clock edge that samples the write.
- R3: pin_oe equals the direction register: bit n = 1 drives pin n as an output, bit n = 0 leaves it an input.
- R4: pin_out always presents the output data register. A value loaded while a pin is an input appears on that pin as soon as its direction bit is set.
- R5: Reading offset 0x00 returns pin_in after two synchronizer flops. A pin change driven before clock edge k reads back after edge k+1.
- R6: A 0-to-1 change of a synchronized pin with its rising enable set, or a 1-to-0 change with its falling enable set, sets that pin's status bit. The bit is set at edge k+2 for a pin change ahead of edge k.
- R7: Writing offset 0x48 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R8: irq is 1 exactly when some status bit is 1 and its forwarding-mask bit is also 1.
- R9: When an edge and a clear of the same status bit fall on the same clock edge, the bit remains 1.
- R10: Reads of 0x0C, 0x30, 0x3C and 0x48 return direction, rising enable, falling enable and status. Writes to 0x0C, 0x30 and 0x3C replace the whole register. Every alias address, and any unmapped address including addresses with upper bits set, reads 0.
- R11: A pin transition whose enable for that direction is 0 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 32 | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output data towards the pads |
| pin_oe | output | 32 | Output enable per pad |
| irq | output | 1 | Combined, masked edge interrupt |

## Verification
The hardest case to produce is a status bit that gets a new edge on exactly the clock edge where software clears it. The pin change must be placed two edges ahead of the clear write so that it has passed through the synchronizer just in time. The stimulus does this once on purpose: it drives a falling pin, waits two cycles, and then issues the clearing write. A long pseudo-random phase follows, mixing pin toggles with writes to every address. This produces many more same-cycle collisions, all of which are checked against a behavioural model on every clock.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and types of the GPIO bank.
// Assumes byte offsets fit in 8 bits; the decoder zero-extends them.
package gpio_bank_pkg;

    localparam int unsigned OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_LEVEL    = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DIR      = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_OUT_SET  = 8'h18;
    localparam logic [OFS_W-1:0] OFS_OUT_CLR  = 8'h24;
    localparam logic [OFS_W-1:0] OFS_RISE     = 8'h30;
    localparam logic [OFS_W-1:0] OFS_FALL     = 8'h3C;
    localparam logic [OFS_W-1:0] OFS_STAT     = 8'h48;
    localparam logic [OFS_W-1:0] OFS_DIR_SET  = 8'h54;
    localparam logic [OFS_W-1:0] OFS_DIR_CLR  = 8'h60;
    localparam logic [OFS_W-1:0] OFS_RISE_SET = 8'h6C;
    localparam logic [OFS_W-1:0] OFS_RISE_CLR = 8'h78;
    localparam logic [OFS_W-1:0] OFS_FALL_SET = 8'h84;
    localparam logic [OFS_W-1:0] OFS_FALL_CLR = 8'h90;
    localparam logic [OFS_W-1:0] OFS_FWD_SET  = 8'h9C;
    localparam logic [OFS_W-1:0] OFS_FWD_CLR  = 8'hA8;

    // One flag per decoded register address; at most one is set.
    typedef struct packed {
        logic level;
        logic dir;
        logic out_set;
        logic out_clr;
        logic rise;
        logic fall;
        logic stat;
        logic dir_set;
        logic dir_clr;
        logic rise_set;
        logic rise_clr;
        logic fall_set;
        logic fall_clr;
        logic fwd_set;
        logic fwd_clr;
    } addr_hit_t;

endpackage

// File: rtl/gpio_bank_decode.sv
// Module: address decoder of the GPIO bank.
// Compares the full address against each register offset, so any
// address with upper bits set decodes to nothing. Purely combinational.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_hit_t         hit
);

    localparam int unsigned PAD_W = ADDR_W - OFS_W;

    // Turns an 8-bit offset into a full-width address.
    function automatic logic [ADDR_W-1:0] widen(input logic [OFS_W-1:0] ofs);
        return {{PAD_W{1'b0}}, ofs};
    endfunction

    // Match the address against every offset.
    always_comb begin
        hit          = '0;
        hit.level    = (addr == widen(OFS_LEVEL));
        hit.dir      = (addr == widen(OFS_DIR));
        hit.out_set  = (addr == widen(OFS_OUT_SET));
        hit.out_clr  = (addr == widen(OFS_OUT_CLR));
        hit.rise     = (addr == widen(OFS_RISE));
        hit.fall     = (addr == widen(OFS_FALL));
        hit.stat     = (addr == widen(OFS_STAT));
        hit.dir_set  = (addr == widen(OFS_DIR_SET));
        hit.dir_clr  = (addr == widen(OFS_DIR_CLR));
        hit.rise_set = (addr == widen(OFS_RISE_SET));
        hit.rise_clr = (addr == widen(OFS_RISE_CLR));
        hit.fall_set = (addr == widen(OFS_FALL_SET));
        hit.fall_clr = (addr == widen(OFS_FALL_CLR));
        hit.fwd_set  = (addr == widen(OFS_FWD_SET));
        hit.fwd_clr  = (addr == widen(OFS_FWD_CLR));
    end

    // Every address selects at most one register (R10).
    always_comb begin
        assert ($onehot0(hit))
            else $error("p_decode_onehot_r10: several registers selected");
    end

endmodule

// File: rtl/gpio_setclr_reg.sv
// Module: one control word with a whole-word load plus set and clear
// strobes that use the data word as a bit mask.
// Assumes load, set and clr come from distinct addresses, so at most
// one of them is active in a cycle.
module gpio_setclr_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             set,
    input  logic             clr,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;

    // Turn the strobes into per-bit masks.
    always_comb begin
        set_mask = set ? data : '0;
        clr_mask = clr ? data : '0;
    end

    // Register update: reset, whole load, or masked set/clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= data;
        end else begin
            q <= (q | set_mask) & ~clr_mask;
        end
    end

    // A set strobe leaves every written one set (R2).
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !load) |=> ((q & $past(data)) == $past(data)));

    // A clear strobe leaves every written one cleared (R2).
    p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> ((q & $past(data)) == '0));

    // Without any strobe the word is held (R2).
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(set || clr || load) |=> $stable(q));

endmodule

// File: rtl/gpio_edge_detect.sv
// Module: pin synchronizer, edge detector and sticky edge status.
// Assumes pin_in is asynchronous; SYNC_STAGES flops (at least 2)
// resynchronize it. An edge compares the last stage with its value
// one cycle earlier. A new edge overrides a clear of the same bit.
module gpio_edge_detect #(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] status
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] sync_q [SYNC_STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] en_any;

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                sync_q[i] <= '0;
            end
        end else begin
            sync_q[0] <= pin_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // Enabled rising or falling transitions this cycle.
    always_comb begin
        set_vec = (sync_q[LAST] & ~prev_q & rise_en)
                | (~sync_q[LAST] & prev_q & fall_en);
        en_any  = rise_en | fall_en;
    end

    // Sticky status: clear on request, but a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    assign level  = sync_q[LAST];
    assign status = status_q;

    // An edge seen in the same cycle as its clear survives (R9).
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // A cleared bit with no new edge reads back as 0 (R7).
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    // Newly set status bits need an enable in the prior cycle (R11).
    p_enable_needed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_any)) == '0));

endmodule

// File: rtl/gpio_edge_bank.sv
// Module: top of one 32-pin GPIO bank with edge interrupts.
// Assumes a single-cycle register write port and a combinational read.
// Pads are driven straight from the output and direction registers.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [PIN_W-1:0]  reg_wdata,
    output logic [PIN_W-1:0]  reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq
);

    addr_hit_t        hit;
    addr_hit_t        wr;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] out_q;
    logic [PIN_W-1:0] rise_q;
    logic [PIN_W-1:0] fall_q;
    logic [PIN_W-1:0] fwd_q;
    logic [PIN_W-1:0] level;
    logic [PIN_W-1:0] status;
    logic [PIN_W-1:0] stat_clr;

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .hit  (hit)
    );

    // Qualify the decoded address with the write strobe.
    always_comb begin
        wr       = reg_wr_en ? hit : '0;
        stat_clr = wr.stat ? reg_wdata : '0;
    end

    gpio_setclr_reg #(.WIDTH(PIN_W)) u_dir (
        .clk (clk), .rst_n (rst_n), .load (wr.dir),
        .set (wr.dir_set), .clr (wr.dir_clr), .data (reg_wdata), .q (dir_q)
    );

    gpio_setclr_reg #(.WIDTH(PIN_W)) u_out (
        .clk (clk), .rst_n (rst_n), .load (1'b0),
        .set (wr.out_set), .clr (wr.out_clr), .data (reg_wdata), .q (out_q)
    );

    gpio_setclr_reg #(.WIDTH(PIN_W)) u_rise (
        .clk (clk), .rst_n (rst_n), .load (wr.rise),
        .set (wr.rise_set), .clr (wr.rise_clr), .data (reg_wdata), .q (rise_q)
    );

    gpio_setclr_reg #(.WIDTH(PIN_W)) u_fall (
        .clk (clk), .rst_n (rst_n), .load (wr.fall),
        .set (wr.fall_set), .clr (wr.fall_clr), .data (reg_wdata), .q (fall_q)
    );

    gpio_setclr_reg #(.WIDTH(PIN_W)) u_fwd (
        .clk (clk), .rst_n (rst_n), .load (1'b0),
        .set (wr.fwd_set), .clr (wr.fwd_clr), .data (reg_wdata), .q (fwd_q)
    );

    gpio_edge_detect #(.WIDTH(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .rise_en (rise_q),
        .fall_en (fall_q),
        .clr_vec (stat_clr),
        .level   (level),
        .status  (status)
    );

    // Read mux: readable registers only, everything else returns 0.
    always_comb begin
        reg_rdata = '0;
        if (hit.level) reg_rdata = level;
        if (hit.dir)   reg_rdata = dir_q;
        if (hit.rise)  reg_rdata = rise_q;
        if (hit.fall)  reg_rdata = fall_q;
        if (hit.stat)  reg_rdata = status;
    end

    // Pad drive and combined interrupt.
    always_comb begin
        pin_out = out_q;
        pin_oe  = dir_q;
        irq     = |(status & fwd_q);
    end

    // Write-only aliases never return data (R10).
    p_alias_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.out_set || hit.out_clr || hit.dir_set || hit.dir_clr ||
         hit.rise_set || hit.rise_clr || hit.fall_set || hit.fall_clr ||
         hit.fwd_set || hit.fwd_clr) |-> (reg_rdata == '0));

    // With an empty forwarding mask the interrupt stays low (R8).
    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_q == '0) |-> !irq);

    // A masked-in status bit always raises the interrupt (R8).
    p_irq_from_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & fwd_q) != '0) |-> irq);

endmodule

// File: tb/test_gpio_edge_bank.sv
// Bench: directed checks against hand-computed values, then a
// pseudo-random phase compared every clock against a behavioural model.
module test_gpio_edge_bank;

    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    gpio_edge_bank i_gpio_edge_bank (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr),
        .reg_wr_en (reg_wr_en), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_dir = '0, m_out = '0, m_ren = '0, m_fen = '0;
    logic [31:0] m_fwd = '0, m_st = '0;
    logic [31:0] m_pipe [$] = '{32'h0, 32'h0, 32'h0}; // s1, level, previous

    always @(posedge clk) begin
        logic [31:0] edges;
        logic [31:0] clr;
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_ren = '0; m_fen = '0; m_fwd = '0; m_st = '0;
            m_pipe = '{32'h0, 32'h0, 32'h0};
        end else begin
            edges = (m_pipe[1] & ~m_pipe[2] & m_ren) | (~m_pipe[1] & m_pipe[2] & m_fen);
            clr = (reg_wr_en && reg_addr == 32'h48) ? reg_wdata : 32'h0;
            m_st = (m_st & ~clr) | edges;
            if (reg_wr_en) begin
                case (reg_addr)
                    32'h0C: m_dir = reg_wdata;
                    32'h30: m_ren = reg_wdata;
                    32'h3C: m_fen = reg_wdata;
                    32'h18: m_out = m_out | reg_wdata;
                    32'h24: m_out = m_out & ~reg_wdata;
                    32'h54: m_dir = m_dir | reg_wdata;
                    32'h60: m_dir = m_dir & ~reg_wdata;
                    32'h6C: m_ren = m_ren | reg_wdata;
                    32'h78: m_ren = m_ren & ~reg_wdata;
                    32'h84: m_fen = m_fen | reg_wdata;
                    32'h90: m_fen = m_fen & ~reg_wdata;
                    32'h9C: m_fwd = m_fwd | reg_wdata;
                    32'hA8: m_fwd = m_fwd & ~reg_wdata;
                    default: ;
                endcase
            end
            m_pipe.push_front(pin_in);
            void'(m_pipe.pop_back());
        end
        cmp_on = 1'b1;
    end

    function automatic logic [31:0] model_read(input logic [31:0] a);
        case (a)
            32'h00:  return m_pipe[1];
            32'h0C:  return m_dir;
            32'h30:  return m_ren;
            32'h3C:  return m_fen;
            32'h48:  return m_st;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [31:0] a);
        case (a)
            32'h00:  return "R5";
            32'h48:  return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model just before each rising edge.
    always @(negedge clk) begin
        #(TCK/2 - 1ns);
        if (cmp_on && rst_n) begin
            check(read_tag(reg_addr), reg_rdata, model_read(reg_addr));
            check("R3", pin_oe, m_dir);
            check("R4", pin_out, m_out);
            check("R8", {31'h0, irq}, {31'h0, |(m_st & m_fwd)});
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [31:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1ns;
        check(tag, reg_rdata, exp);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x = v;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    logic [31:0] addr_list [17] = '{32'h00, 32'h0C, 32'h18, 32'h24, 32'h30, 32'h3C,
        32'h48, 32'h54, 32'h60, 32'h6C, 32'h78, 32'h84, 32'h90, 32'h9C, 32'hA8,
        32'h04, 32'h100};

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(TCK * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        rd_check("R1", 32'h0C, 32'h0);
        rd_check("R1", 32'h30, 32'h0);
        rd_check("R1", 32'h3C, 32'h0);
        rd_check("R1", 32'h48, 32'h0);
        check("R1", pin_oe, 32'h0);
        check("R1", pin_out, 32'h0);
        check("R1", {31'h0, irq}, 32'h0);
        tick(1);
        // R4: preload output data while the pins are inputs
        wr(32'h18, 32'hA5A5_0F0F);
        check("R4", pin_out, 32'hA5A5_0F0F);
        check("R4", pin_oe, 32'h0);
        // R2: direction set and clear aliases
        wr(32'h54, 32'h0000_FFFF);
        wr(32'h60, 32'h0000_00F0);
        rd_check("R2", 32'h0C, 32'h0000_FF0F);
        check("R3", pin_oe, 32'h0000_FF0F);
        wr(32'h24, 32'h0000_000F);
        check("R2", pin_out, 32'hA5A5_0F00);
        // R10: direct load of direction and alias reads of zero
        wr(32'h0C, 32'h1234_5678);
        rd_check("R10", 32'h0C, 32'h1234_5678);
        rd_check("R10", 32'h54, 32'h0);
        rd_check("R10", 32'h100, 32'h0);
        tick(1);
        // R11: edges with no enable leave the status alone; R5 level path
        pin_in = 32'hFFFF_FFFF;
        tick(1);
        rd_check("R5", 32'h00, 32'h0);
        tick(1);
        rd_check("R5", 32'h00, 32'hFFFF_FFFF);
        tick(2);
        rd_check("R11", 32'h48, 32'h0);
        // R6: enabled edges latch
        wr(32'h6C, 32'h0000_000F);
        wr(32'h84, 32'h0000_00F0);
        pin_in = 32'h0;
        tick(4);
        rd_check("R6", 32'h48, 32'h0000_00F0);
        pin_in = 32'h0000_00FF;
        tick(4);
        rd_check("R6", 32'h48, 32'h0000_00FF);
        check("R8", {31'h0, irq}, 32'h0);
        wr(32'h9C, 32'h0000_0001);
        check("R8", {31'h0, irq}, 32'h1);
        // R7: partial write-one-to-clear
        wr(32'h48, 32'h0000_000F);
        rd_check("R7", 32'h48, 32'h0000_00F0);
        check("R8", {31'h0, irq}, 32'h0);
        wr(32'h48, 32'h0000_00F0);
        rd_check("R7", 32'h48, 32'h0);
        // R9: falling edge on pin 4 lands on the same edge as its clear
        pin_in = 32'h0000_00EF;
        tick(2);
        wr(32'h48, 32'h0000_0010);
        rd_check("R9", 32'h48, 32'h0000_0010);
        wr(32'h48, 32'h0000_0010);
        rd_check("R9", 32'h48, 32'h0);
        // Random phase, compared against the model on every clock
        seed = 32'h1BAD_5EED;
        for (int i = 0; i < 6000; i++) begin
            seed = xs(seed);
            reg_addr  = addr_list[seed[4:0] % 17];
            reg_wr_en = seed[5] & seed[6];
            seed = xs(seed);
            reg_wdata = seed;
            seed = xs(seed);
            if (seed[0]) pin_in = pin_in ^ (seed & xs(seed) & 32'h8421_1248);
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule